// File: doc/BRIEF.md
# Nibble Handshake Host Port

This block is the device-side end of a four-bit, fully asynchronous host port. Bytes cross the port as two nibbles, low nibble first. Each direction has its own pair of active-low request/accept lines. In a download the host requests and the device accepts. In an upload the device requests and the host accepts. Both host control lines pass through two-flop synchronisers before any logic sees them.

The first byte of every download is a control byte. If its top bit is clear, the byte opens a data packet. Its low five bits give the payload length, and any length above 27 is reduced to 27. The control byte and the payload are forwarded on a byte stream toward the packet buffer. If the top bit is set, the byte requests register access:

- Bit 6 set means a write, and bit 6 clear means a read.
- The low six bits give the address.
- A write carries one data byte and gets no reply.
- A read is answered by an upload of two bytes: the control byte echoed back, then the register value.

Register address 0 is the switch register and is held inside the block. Its bit 2 is a write-enable that must be set before every write to a nonzero address. It clears itself after each such write. Received packets waiting in the upload buffer arrive on a second byte stream and are sent to the host before a new download is accepted.

Both byte streams use valid/ready, and a byte moves when valid and ready are both high on a clock edge. Back-pressure on the download stream holds the host: the accept line for a byte's high nibble stays low until that byte is taken. The upload stream's ready is high for one cycle per byte, and only once the port is free to serialise that byte.

Top module: `hsp_host_port`

## Requirements
- R1: After reset, both device handshake outputs are high, the bus output enable is low, the switch register holds its reset value (0x00), and no stream valid or register strobe is active.
- R2: In a download, the device pulls accept low after the host pulls request low. It latches the bus and raises accept after the host raises request. The first nibble of a pair is bits 3:0 of the byte and the second is bits 7:4.
- R3: While a downloaded byte is offered on the download stream and ready is low, accept stays low, holding the host in the high-nibble handshake.
- R4: A control byte with bit 7 clear is forwarded and followed by N payload bytes, N being bits 4:0 of the control byte. The last flag marks the final byte, or the control byte itself when N is 0.
- R5: A length field above 27 is treated as 27. The byte after the 27th payload byte is decoded as a new control byte.
- R6: A control byte with bits 7 and 6 set is a register write to the address in bits 5:0, with the next byte as the data. A write to address 0 loads the switch register unconditionally. No upload follows a write.
- R7: A write to a nonzero address produces one register write strobe only if switch bit 2 is set, and that bit then clears. With the bit clear, the write is dropped and the register keeps its value.
- R8: A control byte with bit 7 set and bit 6 clear produces one read strobe (external registers are read one cycle later). The reply is an upload of the echoed control byte followed by the register value. Address 0 returns the switch register.
- R9: In an upload, the device pulls request low. After the host pulls accept low, the device drives the nibble and raises request, and it moves on once the host raises accept. The low nibble goes first.
- R10: The bus output enable is low whenever no upload is in progress. It rises only after the host accepts the first nibble of an upload and falls after the last nibble of that upload.
- R11: A byte waiting on the upload stream while the port is idle is sent before a host download request is accepted. The host may hold its request low throughout.
- R12: Each upload-stream byte is consumed exactly once, and the port returns to idle after the byte flagged last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_txr_n | input | 1 | Host download request, active low, asynchronous |
| host_rxa_n | input | 1 | Host upload accept, active low, asynchronous |
| bus_in | input | 4 | Data bus as seen at the pins |
| bus_out | output | 4 | Nibble driven during uploads |
| bus_oe | output | 1 | Bus output enable |
| dev_txa_n | output | 1 | Device download accept, active low |
| dev_rxr_n | output | 1 | Device upload request, active low |
| sw_q | output | 8 | Switch register (address 0) |
| dl_valid | output | 1 | Download byte valid |
| dl_ready | input | 1 | Packet buffer ready |
| dl_data | output | 8 | Download byte |
| dl_last | output | 1 | Final byte of the data packet |
| ul_valid | input | 1 | Upload byte valid |
| ul_ready | output | 1 | Upload byte taken |
| ul_data | input | 8 | Upload byte |
| ul_last | input | 1 | Final byte of the upload packet |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | 6 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid one cycle after reg_re |

## Verification
The bench tests these cases and the failure each one would expose:

- **Length-field clipping.** A clipping error would swallow or truncate bytes, and the next control byte would decode as payload.
- **Write-enable clearing.** A missing clear lets a second unguarded write through, which shows up as an unexpected strobe and a changed read-back.
- **Back-pressure on the high nibble.** A design that released accept early would drop a byte, and the downloaded stream would no longer match what the host sent.
- **Upload-before-download ordering.** The host holds its request low while an upload is waiting. A design with the wrong priority grants accept before the upload ends and deadlocks the exchange or reorders it.
- **Bus-enable window.** The enable is checked against the host's accept, because a late or early enable makes the host read stale nibbles.

// File: rtl/hsp_pkg.sv
`timescale 1ns/1ps
package hsp_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_DL_CTRL, PH_DL_PAY, PH_DL_WDATA,
    PH_RD_ISSUE, PH_RD_CAP, PH_UL_PKT, PH_UL_RSP, PH_UL_DRAIN
  } phase_e;
  typedef enum logic [1:0] {RX_WAIT, RX_HOLD, RX_BYTE} rx_st_e;
  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_SETUP, TX_DATA} tx_st_e;
endpackage

// File: rtl/hsp_sync.sv
`timescale 1ns/1ps
module hsp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hsp_ctl_decode.sv
`timescale 1ns/1ps
module hsp_ctl_decode #(
  parameter int BW      = 8,
  parameter int ADDR_W  = 6,
  parameter int LEN_W   = 5,
  parameter int MAX_LEN = 27,
  parameter int CNT_W   = 5
) (
  input  logic [BW-1:0]     ctrl,
  output logic              is_reg,
  output logic              is_wr,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  plen
);
  logic [LEN_W-1:0] raw_len;

  assign is_reg  = ctrl[BW-1];
  assign is_wr   = ctrl[BW-2];
  assign addr    = ctrl[ADDR_W-1:0];
  assign raw_len = ctrl[LEN_W-1:0];

  // R5: clip only when the field can exceed the limit
  generate
    if ((1 << LEN_W) - 1 > MAX_LEN) begin : g_clip
      assign plen = (CNT_W'(raw_len) > CNT_W'(MAX_LEN)) ? CNT_W'(MAX_LEN) : CNT_W'(raw_len);
    end else begin : g_pass
      assign plen = CNT_W'(raw_len);
    end
  endgenerate
endmodule

// File: rtl/hsp_nib_rx.sv
`timescale 1ns/1ps
module hsp_nib_rx
  import hsp_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            req,
  input  logic [NW-1:0]   nib_in,
  output logic            acc,
  output logic            busy,
  output logic            byte_valid,
  output logic [2*NW-1:0] byte_data,
  input  logic            byte_ready
);
  rx_st_e          st;
  logic            hi;
  logic [NW-1:0]   lo_q;
  logic [2*NW-1:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_WAIT;
      hi     <= 1'b0;
      lo_q   <= '0;
      byte_q <= '0;
    end else begin
      case (st)
        RX_WAIT: if (req && en) st <= RX_HOLD;
        RX_HOLD: if (!req) begin
          if (hi) begin
            byte_q <= {nib_in, lo_q};
            st     <= RX_BYTE;
          end else begin
            lo_q <= nib_in;
            hi   <= 1'b1;
            st   <= RX_WAIT;
          end
        end
        RX_BYTE: if (byte_ready) begin
          hi <= 1'b0;
          st <= RX_WAIT;
        end
        default: st <= RX_WAIT;
      endcase
    end
  end

  assign acc        = (st != RX_WAIT);
  assign busy       = (st != RX_WAIT) || hi;
  assign byte_valid = (st == RX_BYTE);
  assign byte_data  = byte_q;

  a_r2_acc_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc) |-> $past(req));
  a_r3_hold_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (acc && byte_valid));
endmodule

// File: rtl/hsp_nib_tx.sv
`timescale 1ns/1ps
module hsp_nib_tx
  import hsp_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2*NW-1:0] in_data,
  input  logic            in_last,
  output logic            in_ready,
  input  logic            acc,
  output logic            rreq,
  output logic            oe,
  output logic [NW-1:0]   nib_out,
  output logic            busy
);
  tx_st_e          st;
  logic            hi;
  logic            last_q;
  logic            oe_q;
  logic [2*NW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= TX_IDLE;
      hi     <= 1'b0;
      last_q <= 1'b0;
      oe_q   <= 1'b0;
      data_q <= '0;
    end else begin
      case (st)
        TX_IDLE: if (in_valid) begin
          data_q <= in_data;
          last_q <= in_last;
          hi     <= 1'b0;
          st     <= TX_REQ;
        end
        TX_REQ: if (acc) begin
          oe_q <= 1'b1;
          st   <= TX_SETUP;
        end
        TX_SETUP: st <= TX_DATA;
        TX_DATA: if (!acc) begin
          if (!hi) begin
            hi <= 1'b1;
            st <= TX_REQ;
          end else begin
            st <= TX_IDLE;
            if (last_q) oe_q <= 1'b0;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign in_ready = (st == TX_IDLE);
  assign rreq     = (st == TX_REQ) || (st == TX_SETUP);
  assign oe       = oe_q;
  assign nib_out  = hi ? data_q[2*NW-1:NW] : data_q[NW-1:0];
  assign busy     = (st != TX_IDLE) || oe_q;

  a_r10_oe_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(acc));
  a_r9_nibble_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_DATA) |-> ($stable(nib_out) && oe));
endmodule

// File: rtl/hsp_host_port.sv
`timescale 1ns/1ps
module hsp_host_port
  import hsp_pkg::*;
#(
  parameter int          NW          = 4,
  parameter int          ADDR_W      = 6,
  parameter int          LEN_W       = 5,
  parameter int          MAX_LEN     = 27,
  parameter int          WE_BIT      = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  SW_INIT     = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_txr_n,
  input  logic              host_rxa_n,
  input  logic [NW-1:0]     bus_in,
  output logic [NW-1:0]     bus_out,
  output logic              bus_oe,
  output logic              dev_txa_n,
  output logic              dev_rxr_n,
  output logic [2*NW-1:0]   sw_q,
  output logic              dl_valid,
  input  logic              dl_ready,
  output logic [2*NW-1:0]   dl_data,
  output logic              dl_last,
  input  logic              ul_valid,
  output logic              ul_ready,
  input  logic [2*NW-1:0]   ul_data,
  input  logic              ul_last,
  output logic              reg_we,
  output logic              reg_re,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [2*NW-1:0]   reg_wdata,
  input  logic [2*NW-1:0]   reg_rdata
);
  localparam int BW    = 2 * NW;
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic              txr_s, rxa_s;
  logic              rx_en, rx_acc, rx_busy, rx_valid, rx_ready;
  logic [BW-1:0]     rx_byte;
  logic              tx_valid, tx_last, tx_ready, tx_rreq, tx_oe, tx_busy;
  logic [BW-1:0]     tx_data;
  logic              dec_is_reg, dec_is_wr;
  logic [ADDR_W-1:0] dec_addr;
  logic [CNT_W-1:0]  dec_plen;

  phase_e            phase;
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] addr_q;
  logic [BW-1:0]     ctrl_q, rsp_data;
  logic              rsp_idx;
  logic              in_dl;

  hsp_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({host_txr_n, host_rxa_n}), .q({txr_s, rxa_s}));

  hsp_nib_rx #(.NW(NW)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .req(!txr_s), .nib_in(bus_in),
    .acc(rx_acc), .busy(rx_busy), .byte_valid(rx_valid), .byte_data(rx_byte),
    .byte_ready(rx_ready));

  hsp_nib_tx #(.NW(NW)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_data(tx_data),
    .in_last(tx_last), .in_ready(tx_ready), .acc(!rxa_s), .rreq(tx_rreq),
    .oe(tx_oe), .nib_out(bus_out), .busy(tx_busy));

  hsp_ctl_decode #(.BW(BW), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN),
                   .CNT_W(CNT_W)) u_dec (
    .ctrl(rx_byte), .is_reg(dec_is_reg), .is_wr(dec_is_wr), .addr(dec_addr),
    .plen(dec_plen));

  assign dev_txa_n = !rx_acc;
  assign dev_rxr_n = !tx_rreq;
  assign bus_oe    = tx_oe;
  assign in_dl     = (phase == PH_DL_CTRL) || (phase == PH_DL_PAY) || (phase == PH_DL_WDATA);
  // R11: a waiting upload blocks the start of a download
  assign rx_en     = in_dl || ((phase == PH_IDLE) && !ul_valid);
  assign reg_addr  = addr_q;
  assign reg_wdata = rx_byte;
  assign reg_we    = (phase == PH_DL_WDATA) && rx_valid && (addr_q != '0) && sw_q[WE_BIT];
  assign reg_re    = (phase == PH_RD_ISSUE) && (addr_q != '0);

  always_comb begin
    dl_valid = 1'b0;
    dl_data  = rx_byte;
    dl_last  = 1'b0;
    rx_ready = 1'b0;
    case (phase)
      PH_DL_CTRL: if (rx_valid) begin
        if (!dec_is_reg) begin
          dl_valid = 1'b1;
          dl_last  = (dec_plen == '0);
          rx_ready = dl_ready;
        end else begin
          rx_ready = 1'b1;
        end
      end
      PH_DL_PAY: begin
        dl_valid = rx_valid;
        dl_last  = (remain == CNT_W'(1));
        rx_ready = dl_ready;
      end
      PH_DL_WDATA: rx_ready = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = ctrl_q;
    tx_last  = 1'b0;
    ul_ready = 1'b0;
    case (phase)
      PH_UL_PKT: begin
        tx_valid = ul_valid;
        tx_data  = ul_data;
        tx_last  = ul_last;
        ul_ready = tx_ready;
      end
      PH_UL_RSP: begin
        tx_valid = 1'b1;
        tx_data  = rsp_idx ? rsp_data : ctrl_q;
        tx_last  = rsp_idx;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      remain   <= '0;
      addr_q   <= '0;
      ctrl_q   <= '0;
      rsp_data <= '0;
      rsp_idx  <= 1'b0;
      sw_q     <= SW_INIT;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (rx_busy)       phase <= PH_DL_CTRL;
          else if (ul_valid) phase <= PH_UL_PKT;
        end
        PH_DL_CTRL: if (rx_valid && rx_ready) begin
          ctrl_q <= rx_byte;
          addr_q <= dec_addr;
          if (!dec_is_reg) begin
            remain <= dec_plen;
            phase  <= (dec_plen == '0) ? PH_IDLE : PH_DL_PAY;
          end else if (dec_is_wr) begin
            phase <= PH_DL_WDATA;
          end else begin
            phase <= PH_RD_ISSUE;
          end
        end
        PH_DL_PAY: if (rx_valid && rx_ready) begin
          remain <= remain - CNT_W'(1);
          if (remain == CNT_W'(1)) phase <= PH_IDLE;
        end
        PH_DL_WDATA: if (rx_valid) begin
          if (addr_q == '0)      sw_q <= rx_byte;
          else if (sw_q[WE_BIT]) sw_q[WE_BIT] <= 1'b0;
          phase <= PH_IDLE;
        end
        PH_RD_ISSUE: phase <= PH_RD_CAP;
        PH_RD_CAP: begin
          rsp_data <= (addr_q == '0) ? sw_q : reg_rdata;
          rsp_idx  <= 1'b0;
          phase    <= PH_UL_RSP;
        end
        PH_UL_RSP: if (tx_valid && tx_ready) begin
          if (rsp_idx) phase <= PH_UL_DRAIN;
          else         rsp_idx <= 1'b1;
        end
        PH_UL_PKT: if (ul_valid && ul_ready && ul_last) phase <= PH_UL_DRAIN;
        PH_UL_DRAIN: if (!tx_busy) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r10_no_drive_in_download: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> !bus_oe);
  a_r7_we_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !sw_q[WE_BIT]);
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CNT_W'(MAX_LEN));
  a_r4_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_valid && dl_ready && dl_last) |=> (phase == PH_IDLE));
  a_r11_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_busy && tx_busy));
endmodule

// File: tb/hsp_host_port_test.sv
`timescale 1ns/1ps
module hsp_host_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txr_n = 1'b1, rxa_n = 1'b1;
  logic [3:0] host_bus = 4'hF;
  logic [3:0] bus_out;
  logic       bus_oe, dev_txa_n, dev_rxr_n;
  logic [7:0] sw_q;
  logic       dl_valid, dl_ready = 1'b1, dl_last;
  logic [7:0] dl_data;
  logic       ul_valid = 1'b0, ul_ready, ul_last = 1'b0;
  logic [7:0] ul_data = 8'h00;
  logic       reg_we, reg_re;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata = 8'h00;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0]  exp_dl [$];
  logic [13:0] exp_wr [$];
  logic [8:0]  ul_src [$];
  logic [7:0]  mem [64];
  bit          ul_take = 0;
  time         first_acc = 0, ul_end = 0;

  always #4 clk = ~clk;

  hsp_host_port uut (
    .clk(clk), .rst_n(rst_n), .host_txr_n(txr_n), .host_rxa_n(rxa_n),
    .bus_in(host_bus), .bus_out(bus_out), .bus_oe(bus_oe),
    .dev_txa_n(dev_txa_n), .dev_rxr_n(dev_rxr_n), .sw_q(sw_q),
    .dl_valid(dl_valid), .dl_ready(dl_ready), .dl_data(dl_data), .dl_last(dl_last),
    .ul_valid(ul_valid), .ul_ready(ul_ready), .ul_data(ul_data), .ul_last(ul_last),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // register file model: synchronous read
  always @(posedge clk) if (reg_re) reg_rdata <= mem[reg_addr];

  // scoreboard monitor
  always @(negedge clk) begin
    ul_take = ul_valid && ul_ready;
    if (dl_valid && dl_ready) begin
      if (exp_dl.size() == 0) check(1'b0, "R4 unexpected download byte", {dl_last, dl_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_dl.pop_front();
        check({dl_last, dl_data} == e, "R2/R4 download byte", {dl_last, dl_data}, e);
      end
    end
    if (reg_we) begin
      if (exp_wr.size() == 0) check(1'b0, "R7 unexpected register write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [13:0] w;
        w = exp_wr.pop_front();
        check({reg_addr, reg_wdata} == w, "R6/R7 register write", {reg_addr, reg_wdata}, w);
      end
      mem[reg_addr] = reg_wdata;
    end
  end

  // upload stream source
  always @(posedge clk) begin
    #1;
    if (ul_take && ul_src.size() > 0) void'(ul_src.pop_front());
    if (ul_src.size() > 0) begin
      {ul_last, ul_data} = ul_src[0];
      ul_valid = 1'b1;
    end else begin
      ul_valid = 1'b0;
    end
  end

  task automatic send_nib(input logic [3:0] n);
    txr_n = 1'b0;
    while (dev_txa_n) tick;
    if (first_acc == 0) first_acc = $time;
    check(!bus_oe, "R10 enable low during download", bus_oe, 0);
    host_bus = n;
    tick;
    txr_n = 1'b1;
    while (!dev_txa_n) tick;
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_nib(b[3:0]);
    send_nib(b[7:4]);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic [3:0] n [2];
    for (int k = 0; k < 2; k++) begin
      while (dev_rxr_n) tick;
      rxa_n = 1'b0;
      while (!dev_rxr_n) tick;
      check(bus_oe, "R9/R10 bus driven when request rises", bus_oe, 1);
      n[k] = bus_out;
      tick;
      rxa_n = 1'b1;
      tick;
    end
    b = {n[1], n[0]};
  endtask

  task automatic send_pkt(input logic [7:0] ctrl, input int nsend, input logic [7:0] seed);
    int len;
    len = (ctrl[4:0] > 27) ? 27 : int'(ctrl[4:0]);
    exp_dl.push_back({(len == 0), ctrl});
    for (int k = 0; k < len; k++)
      exp_dl.push_back({(k == len - 1), 8'(seed + 8'(k * 7))});
    send_byte(ctrl);
    for (int k = 0; k < nsend; k++) send_byte(8'(seed + 8'(k * 7)));
    host_bus = 4'hF;
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    send_byte({2'b11, a});
    send_byte(d);
    host_bus = 4'hF;
    repeat (6) tick;
  endtask

  task automatic rd_reg(input logic [5:0] a, input logic [7:0] exp_d, input string tag);
    logic [7:0] e, d;
    send_byte({2'b10, a});
    host_bus = 4'hF;
    recv_byte(e);
    recv_byte(d);
    check(e == {2'b10, a}, {tag, " echo"}, e, {2'b10, a});
    check(d == exp_d, {tag, " data"}, d, exp_d);
    repeat (8) tick;
    check(!bus_oe, "R10 enable off after reply", bus_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (4) tick;
    rst_n = 1'b1;
    repeat (3) tick;
    // R1 reset state
    check(dev_txa_n && dev_rxr_n, "R1 handshake idle high", {dev_txa_n, dev_rxr_n}, 2'b11);
    check(!bus_oe, "R1 bus enable low", bus_oe, 0);
    check(sw_q == 8'h00, "R1 switch reset value", sw_q, 0);
    check(!dl_valid && !reg_we && !reg_re, "R1 no strobes", {dl_valid, reg_we, reg_re}, 0);

    // R2 R4 data packets
    send_pkt(8'h03, 3, 8'hA5);
    send_pkt(8'h00, 0, 8'h00);
    repeat (5) tick;
    check(exp_dl.size() == 0, "R4 packet fully forwarded", exp_dl.size(), 0);
    check(dev_txa_n, "R2 accept high between packets", dev_txa_n, 1);

    // R5 clipping, then a new control byte
    send_pkt(8'h1F, 27, 8'h10);
    send_pkt(8'h01, 1, 8'hC3);
    repeat (5) tick;
    check(exp_dl.size() == 0, "R5 clip then new packet", exp_dl.size(), 0);

    // R3 back-pressure
    dl_ready = 1'b0;
    fork
      send_pkt(8'h01, 1, 8'h90);
      begin
        while (!dl_valid) tick;
        repeat (12) tick;
        check(!dev_txa_n && dl_valid, "R3 accept held under back-pressure", {dev_txa_n, dl_valid}, 2'b01);
        dl_ready = 1'b1;
      end
    join
    repeat (5) tick;
    check(exp_dl.size() == 0, "R3 bytes intact after stall", exp_dl.size(), 0);

    // R7 guarded writes
    wr_reg(6'd5, 8'h11);
    rd_reg(6'd5, 8'h5F, "R7 dropped write keeps value");
    wr_reg(6'd0, 8'h04);
    check(sw_q == 8'h04, "R6 switch write", sw_q, 8'h04);
    exp_wr.push_back({6'd5, 8'h99});
    wr_reg(6'd5, 8'h99);
    check(sw_q == 8'h00, "R7 enable bit self clears", sw_q, 0);
    check(exp_wr.size() == 0, "R7 guarded write strobed", exp_wr.size(), 0);
    wr_reg(6'd6, 8'h77);
    rd_reg(6'd6, 8'h5C, "R7 second write dropped");
    rd_reg(6'd5, 8'h99, "R8 read external");
    wr_reg(6'd0, 8'h30);
    repeat (20) tick;
    check(dev_rxr_n, "R6 no reply to write", dev_rxr_n, 1);
    rd_reg(6'd0, 8'h30, "R8 read switch");

    // R9 R12 packet upload
    ul_src.push_back({1'b0, 8'h12});
    ul_src.push_back({1'b0, 8'h34});
    ul_src.push_back({1'b1, 8'h56});
    recv_byte(b); check(b == 8'h12, "R9 upload byte 0", b, 8'h12);
    recv_byte(b); check(b == 8'h34, "R9 upload byte 1", b, 8'h34);
    recv_byte(b); check(b == 8'h56, "R9 upload byte 2", b, 8'h56);
    repeat (8) tick;
    check(ul_src.size() == 0 && !ul_valid, "R12 stream consumed once", ul_src.size(), 0);
    check(!bus_oe, "R10 enable off after upload", bus_oe, 0);

    // R11 upload before a held download request
    ul_src.push_back({1'b0, 8'h21});
    ul_src.push_back({1'b1, 8'h43});
    repeat (3) tick;
    first_acc = 0;
    fork
      send_pkt(8'h01, 1, 8'h42);
      begin
        recv_byte(b); check(b == 8'h21, "R11 upload first byte", b, 8'h21);
        recv_byte(b); check(b == 8'h43, "R11 upload second byte", b, 8'h43);
        ul_end = $time;
      end
    join
    repeat (5) tick;
    check(ul_end < first_acc, "R11 upload done before accept", 32'(ul_end), 32'(first_acc));
    check(exp_dl.size() == 0, "R11 download served after", exp_dl.size(), 0);
    check(exp_wr.size() == 0, "R7 no stray writes", exp_wr.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule